// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a scalar floating-point unit that also feeds a SIMD datapath. Software reads and writes the word through a single-cycle register port. A compare unit loads the four condition flags through a strobe. The arithmetic pipeline reports exceptions that build up as sticky flags. These flags stay set until software writes a zero to them, and a dedicated output always shows them.

The block supplies the rounding, flush-to-zero and default-NaN controls to the datapath. A select input chooses the set. With the select low, the controls come from the programmed fields. With the select high, they take the fixed SIMD settings: round to nearest, flush-to-zero on and default NaN on. The half-precision format bit is driven out as stored. The short-vector stride and length fields are only stored and read back.

Top module: `fpcsr_reg`

## Requirements
- R1: A synchronous active-high reset clears every bit of the word to zero, so `sw_rdata` and `exc_flags` read zero after reset.
- R2: When `cmp_valid` is high, the compare code sets bits 31:28 (N,Z,C,V) at the next edge. Code 00 (less) gives 1000, 01 (equal) gives 0110, 10 (greater) gives 0010 and 11 (unordered) gives 0011.
- R3: If `cmp_valid` and `sw_wr_en` are high in the same cycle, bits 31:28 take the compare result and all other writable bits take the written value.
- R4: A software write stores the writable fields, which can be read back on `sw_rdata` from the next cycle. The writable fields are bits 31:28, 26 (alternate half format), 25 (default NaN), 24 (flush to zero), 23:22 (rounding), 21:20 (stride), 18:16 (length), 7 and 4:0.
- R5: Bits 27, 19, 15:8 and 6:5 always read as zero, whatever was written to them.
- R6: A report with `exc_valid` high ORs `exc_report` into the sticky flags at the next edge. The bit order is [5] input denormal (word bit 7), [4] inexact (bit 4), [3] underflow (bit 3), [2] overflow (bit 2), [1] divide by zero (bit 1), [0] invalid (bit 0). A flag clears only when software writes a zero to it.
- R7: If a software write and an exception report fall in the same cycle, the flags become the written value ORed with the report.
- R8: `exc_flags` always equals {word bit 7, word bits 4:0}.
- R9: With `simd_sel` low, `eff_rmode` equals bits 23:22, `eff_ftz` equals bit 24 and `eff_dnan` equals bit 25. The rounding codes are 00 nearest, 01 toward +inf, 10 toward -inf and 11 toward zero.
- R10: With `simd_sel` high, `eff_rmode` is 00, `eff_ftz` is 1 and `eff_dnan` is 1, whatever the word holds.
- R11: `half_alt` always equals bit 26 (0 selects IEEE half precision, 1 the alternate format).
- R12: An `exc_report` with `exc_valid` low has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current word (registered state) |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_code | input | 2 | Compare outcome: 00 less, 01 equal, 10 greater, 11 unordered |
| exc_valid | input | 1 | Exception report strobe |
| exc_report | input | 6 | Exceptions raised by the current operation |
| exc_flags | output | 6 | Sticky exception flags |
| simd_sel | input | 1 | 1 selects the fixed SIMD controls |
| eff_rmode | output | 2 | Effective rounding mode |
| eff_ftz | output | 1 | Effective flush-to-zero |
| eff_dnan | output | 1 | Effective default-NaN mode |
| half_alt | output | 1 | Alternate half-precision format select |

## Verification
A write, a compare strobe or an exception report applied before a rising edge shows on `sw_rdata` and `exc_flags` one cycle later. The bench drives inputs just after a falling edge. It updates its reference model at the rising edge and compares the registered outputs at the next falling edge. The effective controls depend on `simd_sel` through logic with no register in the path, so they are checked in the same cycle, shortly after `simd_sel` is driven and against the stored state of that cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

  localparam int WORD_W = 32;
  localparam int EXC_W  = 6;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    CMP_LT = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GT = 2'b10,
    CMP_UN = 2'b11
  } cmp_code_t;

  localparam logic [1:0] RND_NEAREST = 2'b00;

  typedef struct packed {
    logic       alt_half;
    logic       dflt_nan;
    logic       flush_z;
    logic [1:0] rnd;
    logic [1:0] stride;
    logic [2:0] vlen;
  } ctl_t;

  function automatic logic [FLAG_W-1:0] cmp_to_nzcv(cmp_code_t c);
    case (c)
      CMP_LT:  return 4'b1000;
      CMP_EQ:  return 4'b0110;
      CMP_GT:  return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

endpackage

// File: rtl/fpcsr_cond.sv
module fpcsr_cond
  import fpcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_nzcv,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_code,
  output logic [FLAG_W-1:0] nzcv
);

  always_ff @(posedge clk) begin
    if (rst) begin
      nzcv <= '0;
    end else if (cmp_valid) begin
      nzcv <= cmp_to_nzcv(cmp_code_t'(cmp_code));
    end else if (wr_en) begin
      nzcv <= wr_nzcv;
    end
  end

endmodule

// File: rtl/fpcsr_sticky.sv
module fpcsr_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         rep_valid,
  input  logic [W-1:0] rep,
  output logic [W-1:0] flags
);

  logic [W-1:0] base;
  logic [W-1:0] add;

  always_comb begin
    base = wr_en ? wr_val : flags;
    add  = rep_valid ? rep : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= base | add;
  end

endmodule

// File: rtl/fpcsr_modes.sv
module fpcsr_modes
  import fpcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  ctl_t       wr_ctl,
  input  logic       simd_sel,
  output ctl_t       ctl,
  output logic [1:0] eff_rmode,
  output logic       eff_ftz,
  output logic       eff_dnan
);

  always_ff @(posedge clk) begin
    if (rst)        ctl <= '0;
    else if (wr_en) ctl <= wr_ctl;
  end

  always_comb begin
    if (simd_sel) begin
      eff_rmode = RND_NEAREST;
      eff_ftz   = 1'b1;
      eff_dnan  = 1'b1;
    end else begin
      eff_rmode = ctl.rnd;
      eff_ftz   = ctl.flush_z;
      eff_dnan  = ctl.dflt_nan;
    end
  end

endmodule

// File: rtl/fpcsr_reg.sv
module fpcsr_reg
  import fpcsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wdata,
  output logic [31:0] sw_rdata,
  input  logic        cmp_valid,
  input  logic [1:0]  cmp_code,
  input  logic        exc_valid,
  input  logic [5:0]  exc_report,
  output logic [5:0]  exc_flags,
  input  logic        simd_sel,
  output logic [1:0]  eff_rmode,
  output logic        eff_ftz,
  output logic        eff_dnan,
  output logic        half_alt
);

  logic [FLAG_W-1:0] nzcv;
  ctl_t              ctl;
  ctl_t              wr_ctl;
  logic [EXC_W-1:0]  wr_exc;

  always_comb begin
    wr_ctl.alt_half = sw_wdata[26];
    wr_ctl.dflt_nan = sw_wdata[25];
    wr_ctl.flush_z  = sw_wdata[24];
    wr_ctl.rnd      = sw_wdata[23:22];
    wr_ctl.stride   = sw_wdata[21:20];
    wr_ctl.vlen     = sw_wdata[18:16];
    wr_exc          = {sw_wdata[7], sw_wdata[4:0]};
  end

  fpcsr_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (sw_wr_en),
    .wr_nzcv   (sw_wdata[31:28]),
    .cmp_valid (cmp_valid),
    .cmp_code  (cmp_code),
    .nzcv      (nzcv)
  );

  fpcsr_sticky #(.W(EXC_W)) u_sticky (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (sw_wr_en),
    .wr_val    (wr_exc),
    .rep_valid (exc_valid),
    .rep       (exc_report),
    .flags     (exc_flags)
  );

  fpcsr_modes u_modes (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (sw_wr_en),
    .wr_ctl    (wr_ctl),
    .simd_sel  (simd_sel),
    .ctl       (ctl),
    .eff_rmode (eff_rmode),
    .eff_ftz   (eff_ftz),
    .eff_dnan  (eff_dnan)
  );

  assign half_alt = ctl.alt_half;

  assign sw_rdata = {nzcv, 1'b0, ctl.alt_half, ctl.dflt_nan, ctl.flush_z,
                     ctl.rnd, ctl.stride, 1'b0, ctl.vlen, 8'h00,
                     exc_flags[5], 2'b00, exc_flags[4:0]};

endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk (
  input logic        clk,
  input logic        rst,
  input logic        sw_wr_en,
  input logic [31:0] sw_wdata,
  input logic [31:0] sw_rdata,
  input logic        cmp_valid,
  input logic [1:0]  cmp_code,
  input logic        exc_valid,
  input logic [5:0]  exc_report,
  input logic [5:0]  exc_flags,
  input logic        simd_sel,
  input logic [1:0]  eff_rmode,
  input logic        eff_ftz,
  input logic        eff_dnan,
  input logic        half_alt
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sw_rdata == 32'h0));

  assert_cmp_less_R2: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_code == 2'b00) |=> (sw_rdata[31:28] == 4'b1000));

  assert_cmp_unord_R2: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_code == 2'b11) |=> (sw_rdata[31:28] == 4'b0011));

  assert_cmp_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && sw_wr_en && cmp_code == 2'b01) |=> (sw_rdata[31:28] == 4'b0110));

  assert_write_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && !cmp_valid) |=> (sw_rdata[31:28] == $past(sw_wdata[31:28])));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !sw_wr_en |=> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));

  assert_wr_or_rep_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_wr_en && exc_valid) |=>
      (exc_flags == ({$past(sw_wdata[7]), $past(sw_wdata[4:0])} | $past(exc_report))));

  assert_export_R8: assert property (@(posedge clk) disable iff (rst)
    exc_flags == {sw_rdata[7], sw_rdata[4:0]});

  assert_scalar_R9: assert property (@(posedge clk) disable iff (rst)
    !simd_sel |-> (eff_rmode == sw_rdata[23:22] && eff_ftz == sw_rdata[24]
                   && eff_dnan == sw_rdata[25]));

  assert_simd_R10: assert property (@(posedge clk) disable iff (rst)
    simd_sel |-> (eff_rmode == 2'b00 && eff_ftz && eff_dnan));

  assert_half_R11: assert property (@(posedge clk) disable iff (rst)
    half_alt == sw_rdata[26]);

  assert_no_report_R12: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr_en && !exc_valid) |=> $stable(exc_flags));

endmodule

bind fpcsr_reg fpcsr_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .sw_wr_en   (sw_wr_en),
  .sw_wdata   (sw_wdata),
  .sw_rdata   (sw_rdata),
  .cmp_valid  (cmp_valid),
  .cmp_code   (cmp_code),
  .exc_valid  (exc_valid),
  .exc_report (exc_report),
  .exc_flags  (exc_flags),
  .simd_sel   (simd_sel),
  .eff_rmode  (eff_rmode),
  .eff_ftz    (eff_ftz),
  .eff_dnan   (eff_dnan),
  .half_alt   (half_alt)
);

// File: tb/fpcsr_reg_tb_top.sv
`timescale 1ns/100ps
module fpcsr_reg_tb_top;

  localparam logic [31:0] WMASK = 32'hF7F7_009F;
  localparam int RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_wr_en;
  logic [31:0] sw_wdata;
  logic [31:0] sw_rdata;
  logic        cmp_valid;
  logic [1:0]  cmp_code;
  logic        exc_valid;
  logic [5:0]  exc_report;
  logic [5:0]  exc_flags;
  logic        simd_sel;
  logic [1:0]  eff_rmode;
  logic        eff_ftz;
  logic        eff_dnan;
  logic        half_alt;

  int total = 0;
  int bad   = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  fpcsr_reg dut_i (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
    .exc_valid(exc_valid), .exc_report(exc_report), .exc_flags(exc_flags),
    .simd_sel(simd_sel), .eff_rmode(eff_rmode), .eff_ftz(eff_ftz),
    .eff_dnan(eff_dnan), .half_alt(half_alt)
  );

  function automatic logic [3:0] nzcv_of(logic [1:0] c);
    case (c)
      2'b00:   return 4'b1000;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b0010;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic logic [31:0] next_word(logic [31:0] m, logic wr, logic [31:0] wd,
                                            logic cv, logic [1:0] cc,
                                            logic ev, logic [5:0] er);
    logic [31:0] n;
    n = wr ? (wd & WMASK) : m;
    if (ev) begin
      n[7]   = n[7] | er[5];
      n[4:0] = n[4:0] | er[4:0];
    end
    if (cv) n[31:28] = nzcv_of(cc);
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    sw_wr_en = 1'b0; sw_wdata = '0; cmp_valid = 1'b0; cmp_code = '0;
    exc_valid = 1'b0; exc_report = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model = next_word(model, sw_wr_en, sw_wdata, cmp_valid, cmp_code, exc_valid, exc_report);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(logic [31:0] d);
    sw_wr_en = 1'b1; sw_wdata = d;
    tick();
  endtask

  task automatic check_eff(string tag);
    #0.5;
    if (simd_sel) chk(tag, {28'h0, eff_dnan, eff_ftz, eff_rmode}, 32'h0000_000C);
    else chk(tag, {28'h0, eff_dnan, eff_ftz, eff_rmode}, {28'h0, model[25], model[24], model[23:22]});
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    idle();
    simd_sel = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    chk("R1 word after reset", sw_rdata, 32'h0);
    chk("R1 flags after reset", {26'h0, exc_flags}, 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R4 write all ones", sw_rdata, 32'hF7F7_009F);
    chk("R5 reserved bits zero", sw_rdata & ~WMASK, 32'h0);
    chk("R11 half_alt set", {31'h0, half_alt}, 32'h1);
    wr(32'h0000_0000);
    chk("R6 write zero clears flags", sw_rdata, 32'h0);
    chk("R11 half_alt clear", {31'h0, half_alt}, 32'h0);

    for (int c = 0; c < 4; c++) begin
      cmp_valid = 1'b1; cmp_code = 2'(c);
      tick();
      chk("R2 compare flags", {28'h0, sw_rdata[31:28]}, {28'h0, nzcv_of(2'(c))});
    end

    sw_wr_en = 1'b1; sw_wdata = 32'h90C3_0000; cmp_valid = 1'b1; cmp_code = 2'b01;
    tick();
    chk("R3 compare beats write", sw_rdata, 32'h60C3_0000);

    wr(32'h0);
    exc_valid = 1'b1; exc_report = 6'b100001;
    tick();
    chk("R6 report accumulate 1", sw_rdata, 32'h0000_0081);
    exc_valid = 1'b1; exc_report = 6'b000010;
    tick();
    chk("R6 report accumulate 2", sw_rdata, 32'h0000_0083);
    chk("R8 exported flags", {26'h0, exc_flags}, 32'h0000_0023);
    exc_valid = 1'b0; exc_report = 6'b111111;
    tick();
    chk("R12 report without valid", sw_rdata, 32'h0000_0083);
    sw_wr_en = 1'b1; sw_wdata = 32'h0000_0010; exc_valid = 1'b1; exc_report = 6'b000100;
    tick();
    chk("R7 write with report", sw_rdata, 32'h0000_0014);
    sw_wr_en = 1'b1; sw_wdata = 32'h0000_0000;
    tick();
    chk("R6 write zero clears", {26'h0, exc_flags}, 32'h0);

    for (int r = 0; r < 4; r++) begin
      wr((32'(r) << 22) | (32'(r & 1) << 24) | (32'(r >> 1) << 25));
      simd_sel = 1'b0;
      check_eff("R9 scalar controls");
      simd_sel = 1'b1;
      check_eff("R10 simd controls");
      simd_sel = 1'b0;
    end

    for (int i = 0; i < RAND_CYCLES; i++) begin
      sw_wr_en   = ($urandom % 5) == 0;
      sw_wdata   = $urandom;
      cmp_valid  = ($urandom % 4) == 0;
      cmp_code   = 2'($urandom);
      exc_valid  = ($urandom % 3) == 0;
      exc_report = ($urandom % 2) ? 6'(1 << ($urandom % 6)) : 6'($urandom);
      simd_sel   = 1'($urandom);
      check_eff(simd_sel ? "R10 random simd" : "R9 random scalar");
      chk("R11 random half", {31'h0, half_alt}, {31'h0, model[26]});
      tick();
      chk("R4 R6 random word", sw_rdata, model);
      chk("R8 random export", {26'h0, exc_flags}, {26'h0, model[7], model[4:0]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule